// File: doc/BRIEF.md
# Status Register and Write-Protection Gate

This block keeps the small status register of a serial memory and decides, byte by byte, whether a write into the storage array may proceed. It holds a write-enable latch and a two-bit protection-range field. It takes single-cycle command strobes from the instruction decoder (enable writes, disable writes, load status), the write-protect pin (active low), the busy level and the cycle-complete strobe from the write sequencer, and the address of the byte about to be written.

The protection field fences off an upper region of the array: nothing, the top quarter, the top half or everything. The region boundaries scale with the `DEPTH` parameter. The status byte is offered to the read path at all times. A combinational permit output answers the question "may this address be written now?" for the address presented in the same cycle.

Top module: `statusGuard`

## Requirements
- R1: After reset the write-enable latch is 0 and the protection field is 00, so the status byte reads 0xF0 while busy is low.
- R2: The status byte is laid out as bits 7..4 constant 1, bit 3 the upper protection bit, bit 2 the lower protection bit, bit 1 the write-enable latch, and bit 0 equal to the busy input in the same cycle.
- R3: An enable-writes strobe sets the write-enable latch at the next clock edge.
- R4: A disable-writes strobe clears the write-enable latch at the next edge. When it coincides with an enable-writes strobe, clearing wins.
- R5: A cycle-complete strobe from the sequencer clears the write-enable latch at the next edge, and it wins over a simultaneous enable-writes strobe.
- R6: A load-status strobe copies data bits 3..2 into the protection field only when the latch is 1, the protect pin is high and busy is low. Otherwise the field keeps its value. The other data bits never change the status byte.
- R7: With field 00 and writes open (latch 1, pin high, not busy), the permit output is 1 for every address.
- R8: With field 01, the permit output is 0 for addresses at or above 3*DEPTH/4 and 1 below.
- R9: With field 10, the permit output is 0 for addresses at or above DEPTH/2 and 1 below.
- R10: With field 11, the permit output is 0 for every address.
- R11: While the protect pin is low, the permit output is 0 for every address, whatever the latch holds.
- R12: The permit output is 0 whenever the latch is 0 or busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrenCmd | input | 1 | Enable-writes strobe |
| wrdiCmd | input | 1 | Disable-writes strobe |
| wrsrCmd | input | 1 | Load-status strobe |
| wrsrData | input | 8 | Data byte carried by the load-status strobe |
| cycleDone | input | 1 | Write cycle completed, from the sequencer |
| busy | input | 1 | Internal write in progress, from the sequencer |
| wpN | input | 1 | Write-protect pin, low inhibits writes |
| addr | input | AW | Target byte address, AW = clog2(DEPTH) |
| statusByte | output | 8 | Status byte for the read path |
| writePermit | output | 1 | Write allowed at addr in this cycle |

## Verification
The assertions check, on every cycle, the fixed upper nibble and the mirrored busy bit. They also check the next-edge effects of the enable, disable and cycle-complete strobes, and that the protection field holds steady without a load strobe. Finally they check that the permit output never rises while the pin is low, the latch is clear, busy is high, or the address falls inside the active fenced region. The bench scenarios are needed for the positive side: that an allowed load actually takes the new field, that each refused load leaves it untouched, and that each field value opens exactly the expected addresses over a full scan of the array.

// File: rtl/statusGuardPkg.sv
package statusGuardPkg;

  typedef enum logic [1:0] {
    FENCE_NONE    = 2'b00,
    FENCE_QUARTER = 2'b01,
    FENCE_HALF    = 2'b10,
    FENCE_ALL     = 2'b11
  } fence_e;

  localparam int STATUS_W   = 8;
  localparam int FENCE_LO   = 2;
  localparam logic [3:0] STATUS_TOP = 4'hF;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadFence;
    logic gateOpen;
  } guardCtrl_t;

endpackage

// File: rtl/sgControl.sv
module sgControl
  import statusGuardPkg::*;
(
  input  logic       wrenCmd,
  input  logic       wrdiCmd,
  input  logic       wrsrCmd,
  input  logic       cycleDone,
  input  logic       busy,
  input  logic       wpN,
  input  logic       welQ,
  output guardCtrl_t ctrl
);

  logic writesOpen;

  always_comb begin
    // writes need the latch, the pin released and an idle sequencer
    writesOpen     = welQ & wpN & ~busy;
    ctrl.gateOpen  = writesOpen;
    ctrl.setWel    = wrenCmd;
    ctrl.clrWel    = wrdiCmd | cycleDone;
    ctrl.loadFence = wrsrCmd & writesOpen;
  end

endmodule

// File: rtl/sgDatapath.sv
module sgDatapath
  import statusGuardPkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  guardCtrl_t          ctrl,
  input  logic [STATUS_W-1:0] wrsrData,
  input  logic                busy,
  input  logic [AW-1:0]       addr,
  output logic                welQ,
  output logic [STATUS_W-1:0] statusByte,
  output logic                writePermit
);

  fence_e fenceQ;
  logic   inQuarter;
  logic   inHalf;
  logic   fenceHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      welQ   <= 1'b0;
      fenceQ <= FENCE_NONE;
    end else begin
      if (ctrl.clrWel)      welQ <= 1'b0;
      else if (ctrl.setWel) welQ <= 1'b1;
      if (ctrl.loadFence)   fenceQ <= fence_e'(wrsrData[FENCE_LO +: 2]);
    end
  end

  generate
    if (AW >= 2) begin : gRegion
      assign inQuarter = &addr[AW-1 -: 2];
      assign inHalf    = addr[AW-1];
    end else begin : gTiny
      assign inQuarter = addr[0];
      assign inHalf    = addr[0];
    end
  endgenerate

  always_comb begin
    unique case (fenceQ)
      FENCE_NONE:    fenceHit = 1'b0;
      FENCE_QUARTER: fenceHit = inQuarter;
      FENCE_HALF:    fenceHit = inHalf;
      default:       fenceHit = 1'b1;
    endcase
  end

  assign writePermit = ctrl.gateOpen & ~fenceHit;
  assign statusByte  = {STATUS_TOP, fenceQ, welQ, busy};

endmodule

// File: rtl/statusGuard.sv
module statusGuard
  import statusGuardPkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrenCmd,
  input  logic          wrdiCmd,
  input  logic          wrsrCmd,
  input  logic [7:0]    wrsrData,
  input  logic          cycleDone,
  input  logic          busy,
  input  logic          wpN,
  input  logic [AW-1:0] addr,
  output logic [7:0]    statusByte,
  output logic          writePermit
);

  guardCtrl_t ctrl;
  logic       welQ;

  sgControl uCtrl (
    .wrenCmd  (wrenCmd),
    .wrdiCmd  (wrdiCmd),
    .wrsrCmd  (wrsrCmd),
    .cycleDone(cycleDone),
    .busy     (busy),
    .wpN      (wpN),
    .welQ     (welQ),
    .ctrl     (ctrl)
  );

  sgDatapath #(.DEPTH(DEPTH)) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .wrsrData   (wrsrData),
    .busy       (busy),
    .addr       (addr),
    .welQ       (welQ),
    .statusByte (statusByte),
    .writePermit(writePermit)
  );

endmodule

// File: rtl/statusGuardChecker.sv
module statusGuardChecker #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wrenCmd,
  input logic          wrdiCmd,
  input logic          wrsrCmd,
  input logic          cycleDone,
  input logic          busy,
  input logic          wpN,
  input logic [AW-1:0] addr,
  input logic [7:0]    statusByte,
  input logic          writePermit
);

  AST_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    statusByte[7:4] == 4'hF); // R2
  AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    statusByte[0] == busy); // R2
  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wrenCmd && !wrdiCmd && !cycleDone) |=> statusByte[1]); // R3
  AST_WEL_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrdiCmd |=> !statusByte[1]); // R4
  AST_WEL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cycleDone |=> !statusByte[1]); // R5
  AST_FENCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrsrCmd |=> $stable(statusByte[3:2])); // R6
  AST_FENCE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsrCmd && (!statusByte[1] || !wpN || busy)) |=> $stable(statusByte[3:2])); // R6
  AST_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
    (statusByte[3:2] == 2'b01 && int'(addr) >= (DEPTH / 4) * 3) |-> !writePermit); // R8
  AST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (statusByte[3:2] == 2'b10 && int'(addr) >= DEPTH / 2) |-> !writePermit); // R9
  AST_ALL_FENCED: assert property (@(posedge clk) disable iff (!rst_n)
    (statusByte[3:2] == 2'b11) |-> !writePermit); // R10
  AST_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !wpN |-> !writePermit); // R11
  AST_GATE_NEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    writePermit |-> (statusByte[1] && !busy)); // R12

endmodule

bind statusGuard statusGuardChecker #(.DEPTH(DEPTH)) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrenCmd    (wrenCmd),
  .wrdiCmd    (wrdiCmd),
  .wrsrCmd    (wrsrCmd),
  .cycleDone  (cycleDone),
  .busy       (busy),
  .wpN        (wpN),
  .addr       (addr),
  .statusByte (statusByte),
  .writePermit(writePermit)
);

// File: tb/statusGuard_test.sv
`timescale 1ns/1ps
module statusGuard_test;
  localparam int DEPTH = 128;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n, wrenCmd, wrdiCmd, wrsrCmd, cycleDone, busy, wpN;
  logic [7:0] wrsrData;
  logic [AW-1:0] addr;
  logic [7:0] statusByte;
  logic writePermit;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  statusGuard #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wrenCmd(wrenCmd), .wrdiCmd(wrdiCmd),
    .wrsrCmd(wrsrCmd), .wrsrData(wrsrData), .cycleDone(cycleDone),
    .busy(busy), .wpN(wpN), .addr(addr), .statusByte(statusByte),
    .writePermit(writePermit)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one-cycle strobe driven on a falling edge, result visible at the next falling edge
  task automatic strobe(bit en, bit di, bit sr, bit done, logic [7:0] d);
    @(negedge clk);
    wrenCmd = en; wrdiCmd = di; wrsrCmd = sr; cycleDone = done; wrsrData = d;
    @(negedge clk);
    wrenCmd = 0; wrdiCmd = 0; wrsrCmd = 0; cycleDone = 0; wrsrData = 8'h00;
  endtask

  task automatic setFence(logic [1:0] f);
    strobe(1, 0, 0, 0, 8'h00);
    strobe(0, 0, 1, 0, {4'h0, f, 2'b00});
  endtask

  task automatic scanFence(string req, logic [1:0] f);
    for (int a = 0; a < DEPTH; a++) begin
      bit fenced;
      addr = AW'(a);
      #0.5;
      fenced = (f == 2'b11) || (f == 2'b10 && a >= DEPTH / 2) ||
               (f == 2'b01 && a >= (DEPTH / 4) * 3);
      check(req, int'(writePermit), fenced ? 0 : 1);
    end
  endtask

  task automatic tReset();
    rst_n = 0; wrenCmd = 0; wrdiCmd = 0; wrsrCmd = 0; cycleDone = 0;
    busy = 0; wpN = 1; wrsrData = 0; addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status after reset", statusByte, 8'hF0);
    check("R12 permit after reset", int'(writePermit), 0);
  endtask

  task automatic tLatch();
    strobe(1, 0, 0, 0, 8'h00);
    check("R3 enable sets latch", statusByte, 8'hF2);
    strobe(0, 1, 0, 0, 8'h00);
    check("R4 disable clears latch", statusByte, 8'hF0);
    strobe(1, 0, 0, 0, 8'h00);
    strobe(1, 1, 0, 0, 8'h00);
    check("R4 disable beats enable", statusByte, 8'hF0);
    strobe(1, 0, 0, 0, 8'h00);
    strobe(0, 0, 0, 1, 8'h00);
    check("R5 cycle done clears latch", statusByte, 8'hF0);
    strobe(1, 0, 0, 1, 8'h00);
    check("R5 done beats enable", statusByte, 8'hF0);
    busy = 1; #0.5;
    check("R2 busy bit mirrors input", statusByte, 8'hF1);
    busy = 0; #0.5;
    check("R2 busy bit low", statusByte, 8'hF0);
  endtask

  task automatic tLoadGating();
    strobe(0, 0, 1, 0, 8'hFF);
    check("R6 load refused with latch clear", statusByte, 8'hF0);
    strobe(1, 0, 0, 0, 8'h00);
    wpN = 0;
    strobe(0, 0, 1, 0, 8'h0C);
    check("R6 load refused with pin low", statusByte, 8'hF2);
    wpN = 1; busy = 1;
    strobe(0, 0, 1, 0, 8'h0C);
    busy = 0; #0.5;
    check("R6 load refused while busy", statusByte, 8'hF2);
    strobe(0, 0, 1, 0, 8'h07);
    check("R6 load takes bits 3..2 only", statusByte, 8'hF6);
    strobe(0, 0, 1, 0, 8'hF0);
    check("R6 load ignores other bits", statusByte, 8'hF2);
  endtask

  task automatic tRegions();
    setFence(2'b00);
    check("R7 fence none loaded", statusByte, 8'hF2);
    scanFence("R7 no fence", 2'b00);
    setFence(2'b01);
    check("R8 fence quarter loaded", statusByte, 8'hF6);
    scanFence("R8 quarter fence", 2'b01);
    setFence(2'b10);
    check("R9 fence half loaded", statusByte, 8'hFA);
    scanFence("R9 half fence", 2'b10);
    setFence(2'b11);
    check("R10 fence all loaded", statusByte, 8'hFE);
    scanFence("R10 full fence", 2'b11);
    setFence(2'b00);
  endtask

  task automatic tPinAndGate();
    strobe(1, 0, 0, 0, 8'h00);
    addr = 0;
    wpN = 0; #0.5;
    check("R11 pin low blocks permit", int'(writePermit), 0);
    addr = AW'(DEPTH - 1); #0.5;
    check("R11 pin low blocks top address", int'(writePermit), 0);
    wpN = 1; #0.5;
    check("R11 pin released opens permit", int'(writePermit), 1);
    busy = 1; #0.5;
    check("R12 busy blocks permit", int'(writePermit), 0);
    busy = 0;
    strobe(0, 1, 0, 0, 8'h00);
    check("R12 latch clear blocks permit", int'(writePermit), 0);
  endtask

  initial begin
    tReset();
    tLatch();
    tLoadGating();
    tRegions();
    tPinAndGate();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule